// File: doc/BRIEF.md
# Switch Frame Timing Generator

This block runs from the master clock (nominally 16.384 MHz) and a frame-sync input that an upstream stage has already sampled into the master-clock domain. It holds a frame counter, here called the phase, and decodes from it every timing signal a time-division switch fabric needs. These are a quarter-rate clock (4.096 MHz) and an eighth-rate clock (2.048 MHz), a regenerated active-low frame pulse, a 4 kHz data-memory frame signal with its complement, and an active-low connection-memory frame pulse. The two memory pulses sit at fixed offsets from the frame boundary so that storage blocks clocked by the same master clock line up with the serial frames.

A clock-delay control moves the counter restart one master cycle later than the frame boundary. Every phase-derived output shifts with it. The connection-memory pulse is the exception: it is placed against the boundary itself, so its position in phase terms moves. Until the first frame sync arrives, the clocks run freely from reset and the frame pulses stay inactive.

Top module: `swfab_frame_timer`

## Requirements
- R1: During reset and in the first cycle after reset is released, the phase is 0, `fp_n_o` and `cmfp_n_o` are 1, `dmfp_o` is 1, `dmfp_n_o` is 0, `c4_o` is 0 and `c2_o` is 1.
- R2: `c4_o` is high exactly when phase mod 4 is 2 or 3. `c2_o` is high exactly when phase mod 8 is 0 to 3. Both clocks run before and after synchronisation.
- R3: A frame boundary occurs in a cycle where `fsync_n` is 0 and was 1 in the previous cycle. When `dly_en` is 0 in that cycle, the phase is 0 in the next cycle. Holding `fsync_n` low creates no further boundary.
- R4: When `dly_en` is 1 in the boundary cycle, the phase restarts one cycle later, so it is 0 two cycles after the boundary cycle.
- R5: With no boundary, the phase counts up by one per cycle and wraps from 2047 to 0.
- R6: Once synchronised, `fp_n_o` is 0 exactly at phases 2046, 2047, 0 and 1. Before the first boundary it stays 1.
- R7: Once synchronised, `dmfp_o` changes state exactly when the phase becomes 64, so it toggles once per frame. `dmfp_n_o` is always its complement. Before the first boundary the pair holds 1 and 0.
- R8: Once synchronised, `cmfp_n_o` is 0 for four cycles. With `dly_en` 0 these start at phase 1977, which is 71 cycles before the next boundary. With `dly_en` 1 they start at phase 1979, which is 68 cycles before the boundary that falls at phase 2047. Before the first boundary it stays 1.
- R9: A boundary arriving mid-frame restarts the phase at once. If it lands on the cycle where the phase would have stepped from 63 to 64, `dmfp_o` does not toggle from the abandoned count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync_n | input | 1 | Frame sync, active low, already in the master-clock domain |
| dly_en | input | 1 | Clock delay: restart the phase one cycle after the boundary |
| c4_o | output | 1 | Quarter-rate clock |
| c2_o | output | 1 | Eighth-rate clock |
| fp_n_o | output | 1 | Regenerated frame pulse, active low |
| dmfp_o | output | 1 | Data-memory frame signal, toggles once per frame |
| dmfp_n_o | output | 1 | Complement of `dmfp_o` |
| cmfp_n_o | output | 1 | Connection-memory frame pulse, active low |

## Verification
The counter restart caused by a frame sync can fall in the same cycle as a decode event that belongs to the old count. Three cases matter. The sync can land where the phase would step from 63 to 64 and toggle the data-memory signal. It can land in the middle of a connection-memory pulse. It can land exactly on the natural wrap. The bench places syncs at these phases, with the delay off and with it on. It then compares every output in every cycle against a phase it derives only from the cycle number and the sync times it chose. So a wrongly toggled data-memory signal, a stuck pulse or a shifted restart shows up in the cycle where it occurs.

// File: rtl/sft_pkg.sv
package sft_pkg;
  // Default frame geometry, in master-clock cycles
  localparam int unsigned FRAME_LEN_D  = 2048;
  localparam int unsigned PULSE_LEN_D  = 4;
  localparam int unsigned DM_OFFSET_D  = 64;
  localparam int unsigned CM_LEAD_ND_D = 71;
  localparam int unsigned CM_LEAD_DL_D = 68;

  // True when pos lies in the circular window [start, start+len) of a frame
  function automatic logic in_window(input int unsigned pos, input int unsigned start,
                                     input int unsigned len, input int unsigned frame);
    int unsigned d;
    d = (pos + frame - start) % frame;
    return d < len;
  endfunction
endpackage

// File: rtl/sft_counter.sv
module sft_counter #(
  parameter int unsigned FRAME_LEN = sft_pkg::FRAME_LEN_D,
  localparam int unsigned CW = $clog2(FRAME_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fsync_n,
  input  logic          dly_en,
  output logic [CW-1:0] cnt_o,
  output logic          locked_o,
  output logic          load_o
);
  localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);

  logic fs_q, pend_q, hit;

  assign hit    = fs_q & ~fsync_n;
  assign load_o = pend_q | (hit & ~dly_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q     <= 1'b1;
      pend_q   <= 1'b0;
      cnt_o    <= '0;
      locked_o <= 1'b0;
    end else begin
      fs_q   <= fsync_n;
      pend_q <= hit & dly_en;
      if (load_o)            cnt_o <= '0;
      else if (cnt_o == LAST) cnt_o <= '0;
      else                   cnt_o <= cnt_o + 1'b1;
      if (load_o) locked_o <= 1'b1;
    end
  end

  p_restart_nodly_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !dly_en) |=> (cnt_o == '0));

  p_restart_dly_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && dly_en) |=> ##1 (cnt_o == '0));
endmodule

// File: rtl/sft_clkgen.sv
module sft_clkgen #(
  parameter int unsigned FRAME_LEN = sft_pkg::FRAME_LEN_D,
  parameter int unsigned PULSE_LEN = sft_pkg::PULSE_LEN_D,
  localparam int unsigned CW = $clog2(FRAME_LEN),
  localparam int unsigned FP_START = FRAME_LEN - PULSE_LEN / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  input  logic          locked_i,
  output logic          c4_o,
  output logic          c2_o,
  output logic          fp_n_o
);
  // Quarter-rate clock falls entering phase 0; eighth-rate clock rises there.
  assign c4_o   = cnt_i[1];
  assign c2_o   = ~cnt_i[2];
  assign fp_n_o = ~(locked_i & sft_pkg::in_window(32'(cnt_i), FP_START, PULSE_LEN, FRAME_LEN));

  p_c2_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(c2_o) |=> c2_o);

  p_fp_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_i |-> fp_n_o);
endmodule

// File: rtl/sft_memfp.sv
module sft_memfp #(
  parameter int unsigned FRAME_LEN  = sft_pkg::FRAME_LEN_D,
  parameter int unsigned PULSE_LEN  = sft_pkg::PULSE_LEN_D,
  parameter int unsigned DM_OFFSET  = sft_pkg::DM_OFFSET_D,
  parameter int unsigned CM_LEAD_ND = sft_pkg::CM_LEAD_ND_D,
  parameter int unsigned CM_LEAD_DL = sft_pkg::CM_LEAD_DL_D,
  localparam int unsigned CW = $clog2(FRAME_LEN),
  localparam int unsigned CM_START_ND = FRAME_LEN - CM_LEAD_ND,
  localparam int unsigned CM_START_DL = FRAME_LEN - 1 - CM_LEAD_DL
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  input  logic          locked_i,
  input  logic          load_i,
  input  logic          dly_en,
  output logic          dm_o,
  output logic          cm_n_o
);
  localparam logic [CW-1:0] DM_PRE = CW'(DM_OFFSET - 1);

  int unsigned cm_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   dm_o <= 1'b1;
    else if (locked_i && cnt_i == DM_PRE && !load_i) dm_o <= ~dm_o;
  end

  assign cm_start = dly_en ? CM_START_DL : CM_START_ND;
  assign cm_n_o   = ~(locked_i & sft_pkg::in_window(32'(cnt_i), cm_start, PULSE_LEN, FRAME_LEN));

  p_dm_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dm_o) |-> (cnt_i == CW'(DM_OFFSET)));

  p_dm_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_i |-> dm_o);

  p_cm_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_i |-> cm_n_o);
endmodule

// File: rtl/swfab_frame_timer.sv
module swfab_frame_timer #(
  parameter int unsigned FRAME_LEN  = sft_pkg::FRAME_LEN_D,
  parameter int unsigned PULSE_LEN  = sft_pkg::PULSE_LEN_D,
  parameter int unsigned DM_OFFSET  = sft_pkg::DM_OFFSET_D,
  parameter int unsigned CM_LEAD_ND = sft_pkg::CM_LEAD_ND_D,
  parameter int unsigned CM_LEAD_DL = sft_pkg::CM_LEAD_DL_D
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fsync_n,
  input  logic dly_en,
  output logic c4_o,
  output logic c2_o,
  output logic fp_n_o,
  output logic dmfp_o,
  output logic dmfp_n_o,
  output logic cmfp_n_o
);
  localparam int unsigned CW = $clog2(FRAME_LEN);

  logic [CW-1:0] cnt;
  logic          locked, load;

  sft_counter #(.FRAME_LEN(FRAME_LEN)) u_cnt (
    .clk(clk), .rst_n(rst_n), .fsync_n(fsync_n), .dly_en(dly_en),
    .cnt_o(cnt), .locked_o(locked), .load_o(load)
  );

  sft_clkgen #(.FRAME_LEN(FRAME_LEN), .PULSE_LEN(PULSE_LEN)) u_clk (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .locked_i(locked),
    .c4_o(c4_o), .c2_o(c2_o), .fp_n_o(fp_n_o)
  );

  sft_memfp #(
    .FRAME_LEN(FRAME_LEN), .PULSE_LEN(PULSE_LEN), .DM_OFFSET(DM_OFFSET),
    .CM_LEAD_ND(CM_LEAD_ND), .CM_LEAD_DL(CM_LEAD_DL)
  ) u_mem (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .locked_i(locked), .load_i(load),
    .dly_en(dly_en), .dm_o(dmfp_o), .cm_n_o(cmfp_n_o)
  );

  assign dmfp_n_o = ~dmfp_o;

  p_c4_on_fp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fp_n_o && !$past(fp_n_o) && $fell(c4_o)) |-> !$past(c2_o));
endmodule

// File: tb/swfab_frame_timer_tb.sv
`timescale 1ns/1ps
module swfab_frame_timer_tb_top;
  localparam int FRAME = 2048;
  localparam int CMS_ND = 1977;
  localparam int CMS_DL = 1979;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fsync_n = 1'b1;
  logic dly_en = 1'b0;
  logic c4_o, c2_o, fp_n_o, dmfp_o, dmfp_n_o, cmfp_n_o;

  int total = 0, bad = 0;
  int c = 0, ref0 = 0, new_ref = 0;
  bit synced = 0, pending = 0, prev_fs = 1, cur_d = 0, done = 0;
  logic exp_dm = 1'b1;
  bit resync_seen = 0;

  always #2.5 clk = ~clk;

  swfab_frame_timer dut_i (
    .clk(clk), .rst_n(rst_n), .fsync_n(fsync_n), .dly_en(dly_en),
    .c4_o(c4_o), .c2_o(c2_o), .fp_n_o(fp_n_o), .dmfp_o(dmfp_o),
    .dmfp_n_o(dmfp_n_o), .cmfp_n_o(cmfp_n_o)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cycle=%0d actual=%b expected=%b", tag, c, act, exp);
    end
  endtask

  function automatic int cur_phase();
    return (c - ref0) % FRAME;
  endfunction

  task automatic body(input bit fs, input bit d);
    int ph, cms;
    bit at_restart;
    at_restart = 0;
    if (pending && c == new_ref) begin
      resync_seen = synced;
      ref0 = new_ref; synced = 1; pending = 0; at_restart = 1;
    end
    ph = cur_phase();
    if (synced && ph == 64) exp_dm = ~exp_dm;
    if (c == 0) begin
      chk(fp_n_o, 1'b1, "R1 fp");
      chk(cmfp_n_o, 1'b1, "R1 cm");
      chk(dmfp_o, 1'b1, "R1 dm");
      chk(dmfp_n_o, 1'b0, "R1 dmn");
      chk(c4_o, 1'b0, "R1 c4");
      chk(c2_o, 1'b1, "R1 c2");
    end
    if (at_restart) begin
      // phase 0 shows as frame pulse low and quarter clock low
      if (resync_seen) chk(fp_n_o, 1'b0, "R9 restart");
      else if (cur_d)  chk(fp_n_o, 1'b0, "R4 restart");
      else             chk(fp_n_o, 1'b0, "R3 restart");
    end
    if (!at_restart && synced && ph == 0) chk(fp_n_o, 1'b0, "R5 wrap");
    chk(c4_o, (ph % 4) >= 2, "R2 c4");
    chk(c2_o, (ph % 8) < 4, "R2 c2");
    chk(fp_n_o, !(synced && (ph >= FRAME - 2 || ph < 2)), "R6 fp");
    chk(dmfp_o, exp_dm, "R7 dm");
    chk(dmfp_n_o, ~exp_dm, "R7 dmn");
    cms = cur_d ? CMS_DL : CMS_ND;
    chk(cmfp_n_o, !(synced && ph >= cms && ph < cms + 4), "R8 cm");
    fsync_n = fs;
    dly_en  = d;
    if (prev_fs && !fs) begin
      pending = 1;
      new_ref = c + 1 + int'(d);
    end
    prev_fs = fs;
    cur_d = d;
    c++;
  endtask

  task automatic tick(input bit fs, input bit d);
    @(negedge clk);
    body(fs, d);
  endtask

  task automatic run(input int n, input bit fs, input bit d);
    for (int i = 0; i < n; i++) tick(fs, d);
  endtask

  task automatic sync_at(input int ph, input bit d);
    tick(1'b1, d);
    while (cur_phase() != ph) tick(1'b1, d);
    tick(1'b0, d);
    run(20, 1'b1, d);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    body(1'b1, 1'b0);          // R1: first cycle after release
    run(3000, 1'b1, 1'b0);     // R2, R5 free-running
    // R3: first sync, held low for more than a frame
    sync_at(500, 1'b0);
    run(3000, 1'b0, 1'b0);
    run(5000, 1'b1, 1'b0);
    sync_at(2047, 1'b0);       // R9 restart on the natural wrap
    run(3000, 1'b1, 1'b0);
    sync_at(63, 1'b0);         // R9 restart on the data-memory toggle
    run(3000, 1'b1, 1'b0);
    sync_at(1978, 1'b0);       // R8 restart inside connection pulse
    run(3000, 1'b1, 1'b0);
    run(10, 1'b1, 1'b1);       // R4 delay on
    sync_at(63, 1'b1);
    run(3000, 1'b1, 1'b1);
    sync_at(1200, 1'b1);
    run(5000, 1'b1, 1'b1);
    sync_at(1980, 1'b1);
    run(3000, 1'b1, 1'b1);
    run(3000, 1'b1, 1'b0);
    finish_up();
  end

  initial begin
    #(5.0 * 190000);
    total++;
    bad++;
    $display("FAIL watchdog cycle=%0d actual=running expected=finished", c);
    finish_up();
  end
endmodule